// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Register Control

This block produces one pulse-width modulated output. Its settings sit in two small registers that a host writes and reads through a synchronous port with byte strobes. The control register holds an enable, the output level to use while idle, an 8-bit reload prescale and an 8-bit duty value. A second register holds a 4-bit clock divisor.

Every output period has exactly 256 steps. Each step lasts reload × divisor clocks, with a reload of 0 counting as 256 and a divisor of 0 counting as 1. Within a period the output is high first and then low. The duty value sets how many steps are low, and a duty of 0 stands for 256, so the output stays low for the whole period.

Settings are copied into working registers only at a period boundary or while the block is disabled. A reprogrammed duty, reload or divisor therefore never cuts a period short. Two instances can sit side by side, each on its own clock with its own enable.

Top module: `pwm_gen_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the divisor register (address 1) reads 1 and `pwm_out` is 0.
- R2: Control bit 31 is the enable. With it cleared, `pwm_out` takes the idle level in the clock after the write. With it set, the waveform starts one clock after the write that set it.
- R3: While the enable is clear, `pwm_out` equals control bit 30 (the idle level), for both values of that bit.
- R4: For a duty value D from 1 to 255 (control bits 7:0), each period is 256 − D steps high followed by D steps low.
- R5: A duty value of 0 keeps `pwm_out` low for the entire period.
- R6: One step lasts R × V clocks. R is the reload (control bits 15:8), with 0 meaning 256. V is the divisor (address 1, bits 3:0), with 0 meaning 1.
- R7: Each of the three write strobe lanes updates only its own field and leaves the others unchanged. Lane 3 carries enable and idle level, lane 1 the reload, lane 0 the duty. At address 1, lane 0 carries the divisor.
- R8: Clearing the enable leaves the stored reload and duty values unchanged.
- R9: New duty, reload or divisor values take effect at the next period boundary. A write captured on the clock edge that ends a period takes effect one period later.
- R10: Setting the enable restarts the step and period counters from zero, so the first period after enabling is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, captured on the rising edge |
| wr_addr | input | 1 | Write target: 0 control, 1 divisor |
| wr_strb | input | 4 | Byte-lane write strobes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
A configuration write can arrive in the same clock in which the period counter wraps and reloads its working copy of the settings. The bench provokes this collision by writing a new duty value on exactly the edge that ends a period, and it places a second write in the middle of an earlier period for comparison. The output is sampled on every clock over four consecutive periods, and each period is compared with the duty the bench expects to be in force for it. The mid-period write must govern the next period, and the write on the boundary edge must be deferred by one further period.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
    localparam int REG_W      = 32;
    localparam int CYC_W      = 8;
    localparam int DIV_W      = 4;
    localparam int EN_BIT     = 31;
    localparam int IDLE_BIT   = 30;
    localparam int RELOAD_LSB = 8;
    localparam int DUTY_LSB   = 0;
    localparam logic [CYC_W-1:0] CNT_LAST = {CYC_W{1'b1}};

    typedef struct packed {
        logic             en;
        logic             idle;
        logic [CYC_W-1:0] reload;
        logic [CYC_W-1:0] duty;
    } ctrl_t;

    typedef struct packed {
        logic [CYC_W-1:0] reload;
        logic [CYC_W-1:0] duty;
        logic [DIV_W-1:0] div;
    } cfg_t;

    // Terminal value of the divisor counter; a zero divisor behaves as one.
    function automatic logic [DIV_W-1:0] div_last(input logic [DIV_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

    // Number of high steps in a period; duty 0 encodes 256 low steps.
    function automatic logic [CYC_W:0] high_steps(input logic [CYC_W-1:0] duty);
        logic [CYC_W:0] full;
        full = {1'b1, {CYC_W{1'b0}}};
        return (duty == '0) ? '0 : full - {1'b0, duty};
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [3:0]       wr_strb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output ctrl_t            ctrl,
    output logic [DIV_W-1:0] div
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[29:16], wr_strb[2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            div  <= DIV_W'(1);
        end else if (wr_en) begin
            if (!wr_addr) begin
                if (wr_strb[3]) begin
                    ctrl.en   <= wr_data[EN_BIT];
                    ctrl.idle <= wr_data[IDLE_BIT];
                end
                if (wr_strb[1]) ctrl.reload <= wr_data[RELOAD_LSB +: CYC_W];
                if (wr_strb[0]) ctrl.duty   <= wr_data[DUTY_LSB +: CYC_W];
            end else if (wr_strb[0]) begin
                div <= wr_data[DIV_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[EN_BIT]                 = ctrl.en;
            rd_data[IDLE_BIT]               = ctrl.idle;
            rd_data[RELOAD_LSB +: CYC_W]    = ctrl.reload;
            rd_data[DUTY_LSB +: CYC_W]      = ctrl.duty;
        end else begin
            rd_data[DIV_W-1:0] = div;
        end
    end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic [CYC_W-1:0] reload,
    output logic             step
);
    logic [DIV_W-1:0] pcnt;
    logic [CYC_W-1:0] rcnt;
    logic             p_last;
    logic             r_last;

    assign p_last = (pcnt == div_last(div));
    // reload 0 wraps to 255 here, which gives 256 divided ticks
    assign r_last = (rcnt == CYC_W'(reload - 1'b1));
    assign step   = run && p_last && r_last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
            rcnt <= '0;
        end else if (p_last) begin
            pcnt <= '0;
            rcnt <= r_last ? '0 : rcnt + 1'b1;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             idle,
    input  cfg_t             live,
    input  logic             step,
    output logic             run,
    output cfg_t             shadow,
    output logic [CYC_W-1:0] cnt,
    output logic             wrap,
    output logic             pwm_out
);
    logic cmp_high;

    assign wrap     = step && (cnt == CNT_LAST);
    assign cmp_high = ({1'b0, cnt} < high_steps(shadow.duty));
    assign pwm_out  = (en && run) ? cmp_high : idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            cnt    <= '0;
            shadow <= '{reload: '0, duty: '0, div: DIV_W'(1)};
        end else begin
            run <= en;
            if (!run) begin
                cnt    <= '0;
                shadow <= live;
            end else if (step) begin
                cnt <= cnt + 1'b1;
                if (wrap) shadow <= live;
            end
        end
    end
endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
    import pwm_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [3:0]  wr_strb,
    input  logic [31:0] wr_data,
    input  logic        rd_addr,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    cfg_t             live;
    cfg_t             shadow;
    logic             run;
    logic             step;
    logic             wrap;
    logic [CYC_W-1:0] cnt;

    assign live = '{reload: ctrl.reload, duty: ctrl.duty, div: div};

    pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl    (ctrl),
        .div     (div)
    );

    pwm_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .div    (shadow.div),
        .reload (shadow.reload),
        .step   (step)
    );

    pwm_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.en),
        .idle    (ctrl.idle),
        .live    (live),
        .step    (step),
        .run     (run),
        .shadow  (shadow),
        .cnt     (cnt),
        .wrap    (wrap),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
    import pwm_gen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [3:0]       wr_strb,
    input logic             pwm_out,
    input ctrl_t            ctrl,
    input logic             run,
    input logic             wrap,
    input logic [CYC_W-1:0] cnt,
    input cfg_t             shadow
);
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> (pwm_out == ctrl.idle));

    // R4
    first_step_high_chk: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl.en && cnt == '0 && shadow.duty != '0) |-> pwm_out);

    // R5
    duty_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl.en && shadow.duty == '0) |-> !pwm_out);

    // R7
    strobe_keep_en_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && !wr_strb[3]) |=> $stable(ctrl.en));

    // R8
    disable_keeps_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && wr_strb == 4'b1000) |=> ($stable(ctrl.duty) && $stable(ctrl.reload)));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(shadow));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt == '0));
endmodule

bind pwm_gen_top pwm_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_strb (wr_strb),
    .pwm_out (pwm_out),
    .ctrl    (ctrl),
    .run     (run),
    .wrap    (wrap),
    .cnt     (cnt),
    .shadow  (shadow)
);

// File: tb/tb_pwm_gen_top.sv
module tb_pwm_gen_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [3:0]  wr_strb = 4'b0;
    logic [31:0] wr_data = 32'b0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwm_gen_top dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    function automatic logic [31:0] cword(input bit en, input bit idle,
                                          input logic [7:0] rel, input logic [7:0] duty);
        return {en, idle, 14'b0, rel, duty};
    endfunction

    function automatic bit exp_bit(input int duty, input int rel, input int dv, input int i);
        int r  = (rel == 0) ? 256 : rel;
        int v  = (dv == 0) ? 1 : dv;
        int st = (i / (r * v)) % 256;
        int de = (duty == 0) ? 256 : duty;
        return st < (256 - de);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = 4'b0;
    endtask

    task automatic rd_chk(input bit a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    // Disable, program, enable, then compare one full period sample by sample.
    task automatic measure(input int duty, input int rel, input int dv, input string tag);
        int r = (rel == 0) ? 256 : rel;
        int v = (dv == 0) ? 1 : dv;
        int n = 256 * r * v;
        int de = (duty == 0) ? 256 : duty;
        int highs = 0;
        int bad = 0;
        int first_bad = -1;
        wr(1'b1, 4'b0001, 32'(dv));
        wr(1'b0, 4'b1011, cword(1'b0, 1'b0, 8'(rel), 8'(duty)));
        wr(1'b0, 4'b1000, cword(1'b1, 1'b0, 8'h00, 8'h00));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out != exp_bit(duty, rel, dv, i)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        check(highs == (256 - de) * r * v, {tag, " high clocks"}, highs, (256 - de) * r * v);
        check(bad == 0, {tag, " shape, first bad sample index"}, first_bad, -1);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd_chk(1'b0, 32'h0, "R1 control reset");
        rd_chk(1'b1, 32'h1, "R1 divisor reset");
        check(pwm_out == 1'b0, "R1 output reset", pwm_out, 0);

        // R3 idle level both ways
        wr(1'b0, 4'b1000, cword(1'b0, 1'b1, 8'h0, 8'h0));
        check(pwm_out == 1'b1, "R3 idle level 1", pwm_out, 1);
        wr(1'b0, 4'b1000, cword(1'b0, 1'b0, 8'h0, 8'h0));
        check(pwm_out == 1'b0, "R3 idle level 0", pwm_out, 0);

        // R4 R5 R6 ratio and step length
        measure(0,    1, 1, "R5 duty 0");
        measure(1,    1, 1, "R4 duty 1");
        measure(128,  1, 1, "R4 duty 0x80");
        measure(255,  1, 1, "R4 duty 0xFF");
        measure(128,  3, 2, "R6 reload 3 div 2");
        measure(16,   5, 15, "R6 reload 5 div 15");
        measure(128,  2, 0, "R6 div 0 as 1");

        // R10 restart after a partial period
        repeat (60) @(negedge clk);
        measure(64, 1, 1, "R10 restart");

        // R2 disable takes idle level in the next clock
        wr(1'b0, 4'b1000, cword(1'b0, 1'b1, 8'h0, 8'h0));
        check(pwm_out == 1'b1, "R2 disable to idle", pwm_out, 1);

        // R7 independent lanes
        wr(1'b0, 4'b1011, cword(1'b1, 1'b0, 8'h22, 8'h33));
        wr(1'b0, 4'b0001, cword(1'b0, 1'b1, 8'h99, 8'h44));
        rd_chk(1'b0, cword(1'b1, 1'b0, 8'h22, 8'h44), "R7 duty lane only");
        wr(1'b0, 4'b0010, cword(1'b0, 1'b1, 8'h55, 8'h77));
        rd_chk(1'b0, cword(1'b1, 1'b0, 8'h55, 8'h44), "R7 reload lane only");
        wr(1'b1, 4'b0001, 32'h0000_0007);
        rd_chk(1'b0, cword(1'b1, 1'b0, 8'h55, 8'h44), "R7 divisor write leaves control");
        rd_chk(1'b1, 32'h7, "R7 divisor readback");

        // R8 disable keeps fields
        wr(1'b0, 4'b1000, cword(1'b0, 1'b0, 8'h00, 8'h00));
        rd_chk(1'b0, cword(1'b0, 1'b0, 8'h55, 8'h44), "R8 fields kept on disable");
        check(pwm_out == 1'b0, "R8 output idle after disable", pwm_out, 0);

        // R9 boundary update: mid-period write and write on the wrap edge
        begin
            int bad = 0;
            int first_bad = -1;
            int dsel;
            wr(1'b1, 4'b0001, 32'h1);
            wr(1'b0, 4'b1011, cword(1'b0, 1'b0, 8'd1, 8'h40));
            wr(1'b0, 4'b1000, cword(1'b1, 1'b0, 8'h0, 8'h0));
            for (int i = 0; i < 1024; i++) begin
                @(negedge clk);
                dsel = (i < 256) ? 8'h40 : (i < 768) ? 8'hC0 : 8'h20;
                if (pwm_out != exp_bit(dsel, 1, 1, i % 256)) begin
                    bad++;
                    if (first_bad < 0) first_bad = i;
                end
                if (i == 100) begin
                    wr_en = 1'b1; wr_addr = 1'b0; wr_strb = 4'b0001; wr_data = 32'h0000_00C0;
                end else if (i == 511) begin
                    wr_en = 1'b1; wr_addr = 1'b0; wr_strb = 4'b0001; wr_data = 32'h0000_0020;
                end else begin
                    wr_en = 1'b0; wr_strb = 4'b0;
                end
            end
            check(bad == 0, "R9 boundary update, first bad sample index", first_bad, -1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule